// File: doc/BRIEF.md
# Packet Drop Log and Interrupt Unit

This block sits beside a packet classifier. For each packet it gets one strobe that carries the packet's drop-cause flags, whether its L2 destination address matched, and whether its TCP/UDP checksum was bad. The block keeps a one-shot log of the first drop that software has not masked. It also keeps two clear-on-read counters, one for dropped packets and one for bad checksums. Two address logs record the first parity error in the VLAN membership table and the first parity error in the lookup-result memory.

Three interrupt sources share one status register: VLAN parity, result parity and packet drop. Software clears a status bit by writing 1 to it. Clearing a bit also empties and re-arms the log tied to it. A debug mirror register lets software raise the same three sources by hand. The status bits and the mirror bits pass through one common mask before they reach the single interrupt pin.

The packet strobe has no back-pressure: the block takes every event in the cycle it is presented, so there is no ready signal. The register port has no wait states. Read data is combinational in the cycle `reg_rd` is high, and writes and clear-on-read take effect at that cycle's rising edge.

Top module: `pkt_droplog_irq`

## Requirements
- R1: After reset, every register reads 0 and `irq` is low.
- R2: An event whose causes are not all masked, arriving while the drop log is armed, stores those unmasked causes in the log (address 4) and sets status bit 2. Cause bits: 0 VLAN non-member, 1 result-table drop, 2 class-code drop, 3 L2 address mismatch, 4 TCP control-bit drop.
- R3: A cause whose bit is 1 in the log mask (address 3, bits 4:0) is never recorded. An event whose causes are all masked captures nothing.
- R4: While status bit 2 is set, the drop log is frozen. Writing 1 to status bit 2 clears both the bit and the log and re-arms the log. An event in the same cycle as that clearing write is not captured.
- R5: The status register (address 0) is write-1-to-clear. Bit 0 is VLAN parity, bit 1 is result parity and bit 2 is packet drop. Written 0 bits are unchanged.
- R6: A VLAN parity strobe sets status bit 0 and stores its 12-bit address (address 5). A result parity strobe sets status bit 1 and stores its 8-bit address (address 6). Each log keeps only its first address until its status bit is cleared, and then it reads 0.
- R7: `irq` is the OR of (status OR mirror) AND NOT mask (address 2, bits 2:0). A mask bit of 1 disables its source. `irq` follows a register change one cycle after the edge that made the change.
- R8: The debug mirror (address 1, bits 2:0) can be written and read back, and it raises `irq` through the same mask.
- R9: The drop counter (address 7) counts events that have the L2 match flag and at least one cause bit. The checksum counter (address 8) counts events that have both the L2 match flag and the bad-checksum flag. Events without the L2 match flag are ignored by both counters.
- R10: A counter read returns the current count and leaves the counter at 0. If an increment comes in the cycle of the read, the counter is left at 1.
- R11: Each counter (width `CNT_W`) saturates at all-ones.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| evt_valid | input | 1 | Per-packet event strobe |
| evt_cause | input | 5 | Drop-cause flags |
| evt_l2_match | input | 1 | Packet's L2 address matched |
| evt_bad_csum | input | 1 | Packet's checksum was bad |
| vpar_err | input | 1 | VLAN table parity error strobe |
| vpar_addr | input | VADDR_W | Address of the VLAN parity error |
| rpar_err | input | 1 | Result memory parity error strobe |
| rpar_addr | input | RADDR_W | Address of the result parity error |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_addr | input | 4 | Register address |
| reg_wdata | input | DATA_W | Write data |
| reg_rdata | output | DATA_W | Read data, valid while reg_rd is high, 0 otherwise |
| irq | output | 1 | Interrupt request |

## Verification
Read data is due in the same cycle as `reg_rd`, and it shows the state left by the previous rising edge. A capture, a write or a counter clear shows up on a read in the cycle after its edge, and `irq` changes in that same cycle. The bench drives every input just after a rising edge. It updates its reference model at the rising edge from those held inputs, and it compares `irq` and any read data at the falling edge, when both the design and the model are settled for that cycle.

// File: rtl/droplog_pkg.sv
package droplog_pkg;
  localparam int NUM_CAUSE = 5;
  localparam int NUM_SRC   = 3;
  localparam int ADDR_W    = 4;

  localparam int SB_VPAR = 0;
  localparam int SB_RPAR = 1;
  localparam int SB_DROP = 2;

  typedef enum logic [ADDR_W-1:0] {
    RA_STATUS = 4'd0,
    RA_MIRROR = 4'd1,
    RA_IMASK  = 4'd2,
    RA_LMASK  = 4'd3,
    RA_DLOG   = 4'd4,
    RA_VLOG   = 4'd5,
    RA_RLOG   = 4'd6,
    RA_DCNT   = 4'd7,
    RA_CCNT   = 4'd8
  } reg_addr_e;
endpackage

// File: rtl/oneshot_log.sv
module oneshot_log #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         set,
  input  logic [W-1:0] set_data,
  input  logic         clr,
  output logic         flag,
  output logic [W-1:0] data
);
  // Capture only while empty; a clear only acts on a full cell.
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      flag <= 1'b0;
      data <= '0;
    end else if (!flag && set) begin
      flag <= 1'b1;
      data <= set_data;
    end else if (flag && clr) begin
      flag <= 1'b0;
      data <= '0;
    end
  end
endmodule

// File: rtl/sat_rd_counter.sv
module sat_rd_counter #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         inc,
  input  logic         rd_clr,
  output logic [W-1:0] count
);
  localparam logic [W-1:0] MAXV = '1;

  always_ff @(posedge clk) begin
    if (!rst_n)
      count <= '0;
    else if (rd_clr)
      count <= inc ? W'(1) : '0;
    else if (inc && count != MAXV)
      count <= count + W'(1);
  end
endmodule

// File: rtl/pkt_droplog_irq.sv
module pkt_droplog_irq
  import droplog_pkg::*;
#(
  parameter int CNT_W   = 32,
  parameter int VADDR_W = 12,
  parameter int RADDR_W = 8,
  parameter int DATA_W  = 32
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 evt_valid,
  input  logic [NUM_CAUSE-1:0] evt_cause,
  input  logic                 evt_l2_match,
  input  logic                 evt_bad_csum,
  input  logic                 vpar_err,
  input  logic [VADDR_W-1:0]   vpar_addr,
  input  logic                 rpar_err,
  input  logic [RADDR_W-1:0]   rpar_addr,
  input  logic                 reg_wr,
  input  logic                 reg_rd,
  input  logic [ADDR_W-1:0]    reg_addr,
  input  logic [DATA_W-1:0]    reg_wdata,
  output logic [DATA_W-1:0]    reg_rdata,
  output logic                 irq
);
  localparam int USED_W = NUM_CAUSE;

  logic [NUM_SRC-1:0]   status;
  logic [NUM_SRC-1:0]   mirror_q, imask_q;
  logic [NUM_CAUSE-1:0] lmask_q, dlog;
  logic [VADDR_W-1:0]   vlog;
  logic [RADDR_W-1:0]   rlog;
  logic [CNT_W-1:0]     dcnt, ccnt;
  logic [NUM_SRC-1:0]   stat_clr;
  logic [NUM_CAUSE-1:0] cause_kept;
  logic                 drop_set, dcnt_inc, ccnt_inc, dcnt_rd, ccnt_rd;
  logic                 wdata_unused;

  assign wdata_unused = &{1'b0, reg_wdata[DATA_W-1:USED_W]};

  assign stat_clr   = (reg_wr && reg_addr == RA_STATUS) ? reg_wdata[NUM_SRC-1:0] : '0;
  assign cause_kept = evt_cause & ~lmask_q;
  assign drop_set   = evt_valid && (|cause_kept);
  assign dcnt_inc   = evt_valid && evt_l2_match && (|evt_cause);
  assign ccnt_inc   = evt_valid && evt_l2_match && evt_bad_csum;
  assign dcnt_rd    = reg_rd && reg_addr == RA_DCNT;
  assign ccnt_rd    = reg_rd && reg_addr == RA_CCNT;

  oneshot_log #(.W(NUM_CAUSE)) u_drop_log (
    .clk(clk), .rst_n(rst_n), .set(drop_set), .set_data(cause_kept),
    .clr(stat_clr[SB_DROP]), .flag(status[SB_DROP]), .data(dlog)
  );

  oneshot_log #(.W(VADDR_W)) u_vpar_log (
    .clk(clk), .rst_n(rst_n), .set(vpar_err), .set_data(vpar_addr),
    .clr(stat_clr[SB_VPAR]), .flag(status[SB_VPAR]), .data(vlog)
  );

  oneshot_log #(.W(RADDR_W)) u_rpar_log (
    .clk(clk), .rst_n(rst_n), .set(rpar_err), .set_data(rpar_addr),
    .clr(stat_clr[SB_RPAR]), .flag(status[SB_RPAR]), .data(rlog)
  );

  sat_rd_counter #(.W(CNT_W)) u_drop_cnt (
    .clk(clk), .rst_n(rst_n), .inc(dcnt_inc), .rd_clr(dcnt_rd), .count(dcnt)
  );

  sat_rd_counter #(.W(CNT_W)) u_csum_cnt (
    .clk(clk), .rst_n(rst_n), .inc(ccnt_inc), .rd_clr(ccnt_rd), .count(ccnt)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mirror_q <= '0;
      imask_q  <= '0;
      lmask_q  <= '0;
    end else if (reg_wr) begin
      case (reg_addr)
        RA_MIRROR: mirror_q <= reg_wdata[NUM_SRC-1:0];
        RA_IMASK:  imask_q  <= reg_wdata[NUM_SRC-1:0];
        RA_LMASK:  lmask_q  <= reg_wdata[NUM_CAUSE-1:0];
        default: ;
      endcase
    end
  end

  assign irq = |((status | mirror_q) & ~imask_q);

  always_comb begin
    reg_rdata = '0;
    if (reg_rd) begin
      case (reg_addr)
        RA_STATUS: reg_rdata = DATA_W'(status);
        RA_MIRROR: reg_rdata = DATA_W'(mirror_q);
        RA_IMASK:  reg_rdata = DATA_W'(imask_q);
        RA_LMASK:  reg_rdata = DATA_W'(lmask_q);
        RA_DLOG:   reg_rdata = DATA_W'(dlog);
        RA_VLOG:   reg_rdata = DATA_W'(vlog);
        RA_RLOG:   reg_rdata = DATA_W'(rlog);
        RA_DCNT:   reg_rdata = DATA_W'(dcnt);
        RA_CCNT:   reg_rdata = DATA_W'(ccnt);
        default:   reg_rdata = '0;
      endcase
    end
  end
endmodule

// File: rtl/droplog_chk.sv
module droplog_chk #(
  parameter int CNT_W   = 32,
  parameter int VADDR_W = 12
) (
  input logic               clk,
  input logic               rst_n,
  input logic               evt_valid,
  input logic [4:0]         evt_cause,
  input logic               reg_wr,
  input logic               reg_rd,
  input logic [3:0]         reg_addr,
  input logic [2:0]         wbits,
  input logic [2:0]         status,
  input logic [2:0]         imask,
  input logic [4:0]         lmask,
  input logic [4:0]         dlog,
  input logic [VADDR_W-1:0] vlog,
  input logic [CNT_W-1:0]   dcnt,
  input logic               irq
);
  // R7
  imask_all_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (&imask) |-> !irq);

  // R2
  drop_capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (evt_valid && (|(evt_cause & ~lmask)) && !status[2]) |=> status[2]);

  // R4
  drop_log_frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (status[2] && !(reg_wr && reg_addr == 4'd0 && wbits[2])) |=> $stable(dlog));

  // R6
  vpar_log_frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (status[0] && !(reg_wr && reg_addr == 4'd0 && wbits[0])) |=> $stable(vlog));

  // R10
  dcnt_read_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_rd && reg_addr == 4'd7) |=> (dcnt <= CNT_W'(1)));
endmodule

bind pkt_droplog_irq droplog_chk #(.CNT_W(CNT_W), .VADDR_W(VADDR_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .evt_valid(evt_valid), .evt_cause(evt_cause),
  .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_addr(reg_addr), .wbits(reg_wdata[2:0]),
  .status(status), .imask(imask_q), .lmask(lmask_q), .dlog(dlog), .vlog(vlog),
  .dcnt(dcnt), .irq(irq)
);

// File: tb/pkt_droplog_irq_test.sv
module pkt_droplog_irq_test;
  localparam int CW  = 6;
  localparam int MAX = (1 << CW) - 1;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic evt_valid = 1'b0, evt_l2_match = 1'b0, evt_bad_csum = 1'b0;
  logic [4:0] evt_cause = '0;
  logic vpar_err = 1'b0, rpar_err = 1'b0;
  logic [11:0] vpar_addr = '0;
  logic [7:0] rpar_addr = '0;
  logic reg_wr = 1'b0, reg_rd = 1'b0;
  logic [3:0] reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic irq;

  int checks = 0, errors = 0;
  bit done = 0;

  // reference model state
  int m_stat, m_mirror, m_imask, m_lmask, m_dlog, m_vlog, m_rlog, m_dcnt, m_ccnt;

  always #10 clk = ~clk;

  pkt_droplog_irq #(.CNT_W(CW)) uut (
    .clk(clk), .rst_n(rst_n), .evt_valid(evt_valid), .evt_cause(evt_cause),
    .evt_l2_match(evt_l2_match), .evt_bad_csum(evt_bad_csum),
    .vpar_err(vpar_err), .vpar_addr(vpar_addr), .rpar_err(rpar_err), .rpar_addr(rpar_addr),
    .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .irq(irq)
  );

  function automatic string tag_of(input int a);
    case (a)
      0: return "R5";
      1: return "R8";
      2: return "R7";
      3: return "R3";
      4: return "R2";
      5, 6: return "R6";
      7, 8: return "R10";
      default: return "R1";
    endcase
  endfunction

  function automatic int model_read(input int a);
    case (a)
      0: return m_stat;
      1: return m_mirror;
      2: return m_imask;
      3: return m_lmask;
      4: return m_dlog;
      5: return m_vlog;
      6: return m_rlog;
      7: return m_dcnt;
      8: return m_ccnt;
      default: return 0;
    endcase
  endfunction

  task automatic check(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // Model update at the rising edge from held inputs
  always @(posedge clk) begin
    if (!rst_n) begin
      m_stat = 0; m_mirror = 0; m_imask = 0; m_lmask = 0; m_dlog = 0;
      m_vlog = 0; m_rlog = 0; m_dcnt = 0; m_ccnt = 0;
    end else begin
      int clrb, kept;
      bit dinc, cinc;
      clrb = (reg_wr && reg_addr == 0) ? int'(reg_wdata[2:0]) : 0;
      kept = int'(evt_cause) & ~m_lmask & 31;
      if (!m_stat[2] && evt_valid && kept != 0) begin m_stat[2] = 1; m_dlog = kept; end
      else if (m_stat[2] && clrb[2]) begin m_stat[2] = 0; m_dlog = 0; end
      if (!m_stat[0] && vpar_err) begin m_stat[0] = 1; m_vlog = int'(vpar_addr); end
      else if (m_stat[0] && clrb[0]) begin m_stat[0] = 0; m_vlog = 0; end
      if (!m_stat[1] && rpar_err) begin m_stat[1] = 1; m_rlog = int'(rpar_addr); end
      else if (m_stat[1] && clrb[1]) begin m_stat[1] = 0; m_rlog = 0; end
      if (reg_wr && reg_addr == 1) m_mirror = int'(reg_wdata[2:0]);
      if (reg_wr && reg_addr == 2) m_imask  = int'(reg_wdata[2:0]);
      if (reg_wr && reg_addr == 3) m_lmask  = int'(reg_wdata[4:0]);
      dinc = evt_valid && evt_l2_match && (evt_cause != 0);
      cinc = evt_valid && evt_l2_match && evt_bad_csum;
      if (reg_rd && reg_addr == 7) m_dcnt = dinc ? 1 : 0;
      else if (dinc && m_dcnt < MAX) m_dcnt++;
      if (reg_rd && reg_addr == 8) m_ccnt = cinc ? 1 : 0;
      else if (cinc && m_ccnt < MAX) m_ccnt++;
    end
  end

  // Per-cycle comparison at the falling edge
  always @(negedge clk) begin
    if (rst_n && !done) begin
      check("R7 irq", int'(irq), (((m_stat | m_mirror) & ~m_imask) & 7) != 0 ? 1 : 0);
      if (reg_rd) check(tag_of(int'(reg_addr)), int'(reg_rdata), model_read(int'(reg_addr)));
    end
  end

  task automatic idle();
    evt_valid = 0; evt_cause = 0; evt_l2_match = 0; evt_bad_csum = 0;
    vpar_err = 0; rpar_err = 0; reg_wr = 0; reg_rd = 0; reg_addr = 0; reg_wdata = 0;
  endtask

  task automatic step();
    @(posedge clk); #2;
    idle();
  endtask

  task automatic evt(input logic [4:0] c, input logic l2, input logic bad);
    evt_valid = 1; evt_cause = c; evt_l2_match = l2; evt_bad_csum = bad;
    step();
  endtask

  task automatic wr(input int a, input int d);
    reg_wr = 1; reg_addr = 4'(a); reg_wdata = 32'(d);
    step();
  endtask

  task automatic rd_exp(input int a, input int exp, input string tag);
    reg_rd = 1; reg_addr = 4'(a);
    @(negedge clk);
    check(tag, int'(reg_rdata), exp);
    step();
  endtask

  task automatic irq_exp(input int exp, input string tag);
    @(negedge clk);
    check(tag, int'(irq), exp);
    @(posedge clk); #2;
  endtask

  initial begin
    #(200000 * 20);
    if (!done) begin
      done = 1;
      errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    idle();
    repeat (3) @(posedge clk);
    #2 rst_n = 1;

    // R1 reset state
    for (int a = 0; a < 9; a++) rd_exp(a, 0, "R1 reset value");
    irq_exp(0, "R1 irq low");

    // R2 capture
    evt(5'b00101, 1, 0);
    rd_exp(4, 5, "R2 log causes");
    rd_exp(0, 4, "R2 status drop bit");
    irq_exp(1, "R7 irq from drop");

    // R4 frozen, then clear and re-arm
    evt(5'b10000, 1, 0);
    rd_exp(4, 5, "R4 log frozen");
    evt_valid = 1; evt_cause = 5'b00010; reg_wr = 1; reg_addr = 0; reg_wdata = 4;
    step();
    rd_exp(4, 0, "R4 clear-cycle event dropped");
    rd_exp(0, 0, "R4 status cleared");
    evt(5'b00010, 0, 0);
    rd_exp(4, 2, "R4 re-armed capture");
    wr(0, 4);

    // R3 log mask
    wr(3, 5'b00011);
    evt(5'b00011, 1, 0);
    rd_exp(0, 0, "R3 fully masked no capture");
    evt(5'b01011, 1, 0);
    rd_exp(4, 8, "R3 masked bits dropped");
    wr(0, 4);
    wr(3, 0);

    // R6 parity logs
    vpar_err = 1; vpar_addr = 12'hABC; step();
    vpar_err = 1; vpar_addr = 12'h123; rpar_err = 1; rpar_addr = 8'h5A; step();
    rd_exp(5, 'hABC, "R6 vlan first address");
    rd_exp(6, 'h5A, "R6 result address");
    // R5 write-1-to-clear on bit 0 only
    wr(0, 1);
    rd_exp(0, 2, "R5 w1c keeps other bits");
    rd_exp(5, 0, "R6 vlan log cleared");
    rd_exp(6, 'h5A, "R6 result log kept");

    // R7 mask
    wr(2, 7);
    irq_exp(0, "R7 all masked");
    wr(2, 5);
    irq_exp(1, "R7 result source unmasked");
    wr(0, 7);
    wr(2, 0);
    irq_exp(0, "R7 irq low after clear");

    // R8 mirror
    wr(1, 4);
    rd_exp(1, 4, "R8 mirror readback");
    irq_exp(1, "R8 mirror raises irq");
    wr(2, 4);
    irq_exp(0, "R8 mirror masked");
    wr(1, 0);
    wr(2, 0);

    // R9 / R10 counters: flush first
    rd_exp(7, 4, "R9 drop count so far");
    rd_exp(8, 0, "R9 csum count so far");
    evt(5'b00001, 1, 1);
    evt(5'b00001, 0, 1);
    evt(5'b00000, 1, 1);
    evt(5'b00000, 1, 0);
    rd_exp(7, 1, "R9 drop count L2 gated");
    rd_exp(7, 0, "R10 cleared by read");
    rd_exp(8, 2, "R9 csum count L2 gated");
    evt_valid = 1; evt_cause = 5'b00100; evt_l2_match = 1;
    reg_rd = 1; reg_addr = 7;
    @(negedge clk);
    check("R10 read with increment", int'(reg_rdata), 0);
    step();
    rd_exp(7, 1, "R10 restart at one");
    wr(0, 4);

    // R11 saturation
    for (int i = 0; i < MAX + 8; i++) evt(5'b01000, 1, 1);
    rd_exp(7, MAX, "R11 drop saturates");
    rd_exp(8, MAX, "R11 csum saturates");
    rd_exp(7, 0, "R10 clear after saturation");

    repeat (2) @(posedge clk);
    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule